// File: doc/BRIEF.md
# Exact Wide Fixed-Point Summation Unit

This block keeps a running total of a stream of wide two's complement fixed-point operands. Each operand is a number split into NUM_LIMBS words of 64 bits. Every addition is exact integer arithmetic, with no rounding, so any ordering of the same set of operands leaves the same bits in the total, as long as no overflow occurs. The host splits its values into the fixed-point format before they reach the block. It then streams them in with a valid strobe and reads the total at the end. A clear strobe starts a fresh sum.

A build-time switch selects one of two datapaths. The limb-serial datapath has a single 64-bit adder. It keeps the carry in a register between cycles and adds one limb per cycle, starting at the least significant. The single-cycle datapath chains all limb adders in one combinational path. Both datapaths set a sticky flag when the total leaves the representable range. They detect this from the sign bits of the old total, the operand and the new total.

Top module: `wfx_accum`

## Requirements
- R1: An operand and the total are flat vectors of NUM_LIMBS*64 bits. Word 0, the most significant, sits at the top. Word NUM_LIMBS-1, the least significant, sits in bits [63:0]. An accepted operand adds to the total modulo 2^(64*NUM_LIMBS).
- R2: A carry out of any limb reaches the next more significant limb. Adding 1 to a total whose two lower words are all ones gives exactly 2^128, with NUM_LIMBS=3.
- R3: The overflow flag sets only when the old total and the operand have equal sign bits (bit 63 of word 0) and the new total has the other sign. The wrapped sum is still stored. Opposite-sign operands never set the flag.
- R4: Once set, the overflow flag stays high through any number of further additions until a clear.
- R5: A clear sets the total to zero and drops the flag at the next clock edge. It also aborts a limb-serial addition in progress, and ready is high again after that edge. An operand presented in the same cycle as a clear is dropped.
- R6: In the single-cycle build, ready is always high. An operand presented with valid appears in the total after the next clock edge, and consecutive cycles may each carry an operand.
- R7: In the limb-serial build, ready goes low for exactly NUM_LIMBS-1 cycles after each accepted operand. The full result and any overflow appear after the NUM_LIMBS-th edge, counting the accepting edge as the first.
- R8: After n/2 values and their two's complement negatives are added in any order, the total is exactly zero and the flag is clear.
- R9: After reset the total is zero, the flag is low and ready is high.
- R10: A valid operand presented while ready is low is ignored. Without an accepted operand the total does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clr_i | input | 1 | Clear: zero the total and the flag |
| op_valid_i | input | 1 | Operand strobe |
| op_data_i | input | 64*NUM_LIMBS | Two's complement fixed-point operand, word 0 at the top |
| op_ready_o | output | 1 | Block can accept an operand this cycle |
| sum_o | output | 64*NUM_LIMBS | Running total |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The single-cycle build updates the total and the flag one edge after an accepted operand. The limb-serial build holds ready low for NUM_LIMBS-1 cycles and shows the complete total and flag after the NUM_LIMBS-th edge. Between those points the total holds partial limbs. A behavioural model counts down the same latency from each accepting edge. The total is compared only when the model says the serial unit is idle. Ready and the flag are compared every cycle, on the falling edge. Directed checks are sampled just after the edge where each result is due: carry across limbs, overflow in both directions, clear during a serial addition, and operands offered while busy.

// File: rtl/wfx_acc_pkg.sv
// Shared limb type and width helpers for the wide fixed-point accumulator.
// Assumes 64-bit limbs; everything wider is counted in limbs.
package wfx_acc_pkg;
    localparam int unsigned LIMB_W = 64;
    typedef logic [LIMB_W-1:0] limb_t;

    // Bits needed to index limb positions 0..n-1 (at least one bit).
    function automatic int unsigned pos_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/wfx_limb_add.sv
// One 64-bit limb adder with carry in and carry out.
// The carry out is found from unsigned wraparound: the result is below the
// added operand word, or equals it while a carry came in.
module wfx_limb_add
    import wfx_acc_pkg::*;
(
    input  limb_t a_i,
    input  limb_t b_i,
    input  logic  cin_i,
    output limb_t sum_o,
    output logic  cout_o
);
    limb_t res;

    // Modular limb sum and wraparound carry detection.
    assign res    = a_i + b_i + limb_t'(cin_i);
    assign sum_o  = res;
    assign cout_o = (res < b_i) || ((res == b_i) && cin_i);
endmodule

// File: rtl/wfx_sign_ovf.sv
// Signed overflow test for a two's complement addition.
// Assumes the three inputs are the sign bits of both addends and the result.
module wfx_sign_ovf (
    input  logic acc_sign_i,
    input  logic op_sign_i,
    input  logic res_sign_i,
    output logic ovf_o
);
    // Equal addend signs with a flipped result sign means overflow.
    assign ovf_o = (acc_sign_i == op_sign_i) && (res_sign_i != acc_sign_i);
endmodule

// File: rtl/wfx_core_par.sv
// Single-cycle datapath: a ripple chain of NUM_LIMBS limb adders from the
// least significant limb upward. Takes one operand per cycle; ready is tied high.
module wfx_core_par
    import wfx_acc_pkg::*;
#(
    parameter int unsigned NUM_LIMBS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        op_valid_i,
    input  logic [NUM_LIMBS*LIMB_W-1:0] op_data_i,
    output logic                        op_ready_o,
    output logic [NUM_LIMBS*LIMB_W-1:0] sum_o,
    output logic                        ovf_o
);
    localparam int unsigned TOTAL_W = NUM_LIMBS * LIMB_W;

    logic [TOTAL_W-1:0]   sum_q;
    logic [TOTAL_W-1:0]   sum_nxt;
    logic [NUM_LIMBS-1:0] cy;
    logic                 top_cy_unused;
    logic                 ovf_q;
    logic                 ovf_hit;

    assign cy[0] = 1'b0;

    // Position p counts limbs from the least significant (bits [63:0]).
    for (genvar p = 0; p < NUM_LIMBS; p++) begin : g_limb
        logic co;
        wfx_limb_add u_add (
            .a_i   (sum_q[p*LIMB_W +: LIMB_W]),
            .b_i   (op_data_i[p*LIMB_W +: LIMB_W]),
            .cin_i (cy[p]),
            .sum_o (sum_nxt[p*LIMB_W +: LIMB_W]),
            .cout_o(co)
        );
        if (p < NUM_LIMBS - 1) begin : g_fwd
            assign cy[p+1] = co;
        end else begin : g_top
            assign top_cy_unused = co;
        end
    end

    wfx_sign_ovf u_ovf (
        .acc_sign_i(sum_q[TOTAL_W-1]),
        .op_sign_i (op_data_i[TOTAL_W-1]),
        .res_sign_i(sum_nxt[TOTAL_W-1]),
        .ovf_o     (ovf_hit)
    );

    // Total and sticky flag: reset/clear first, then accept an operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q <= '0;
            ovf_q <= 1'b0;
        end else if (clr_i) begin
            sum_q <= '0;
            ovf_q <= 1'b0;
        end else if (op_valid_i) begin
            sum_q <= sum_nxt;
            if (ovf_hit) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign op_ready_o = 1'b1;
    assign sum_o      = sum_q;
    assign ovf_o      = ovf_q;
endmodule

// File: rtl/wfx_core_ser.sv
// Limb-serial datapath: one shared limb adder and a carry register. The
// accepting edge adds the least significant limb straight from the input and
// stores the upper limbs. The next NUM_LIMBS-1 edges add one limb each, moving
// toward word 0. Overflow is judged on the final (most significant) limb.
module wfx_core_ser
    import wfx_acc_pkg::*;
#(
    parameter int unsigned NUM_LIMBS = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        op_valid_i,
    input  logic [NUM_LIMBS*LIMB_W-1:0] op_data_i,
    output logic                        op_ready_o,
    output logic [NUM_LIMBS*LIMB_W-1:0] sum_o,
    output logic                        ovf_o
);
    localparam int unsigned TOTAL_W = NUM_LIMBS * LIMB_W;
    localparam int unsigned POS_W   = pos_width(NUM_LIMBS);
    localparam int unsigned HI_W    = ((NUM_LIMBS > 1) ? NUM_LIMBS - 1 : 1) * LIMB_W;
    localparam logic [POS_W-1:0] LAST_POS = POS_W'(NUM_LIMBS - 1);

    logic [TOTAL_W-1:0] sum_q;
    logic [HI_W-1:0]    op_hi_q;
    logic [POS_W-1:0]   cnt_q;
    logic               busy_q;
    logic               carry_q;
    logic               ovf_q;

    logic [POS_W-1:0]   pos;
    logic [POS_W-1:0]   hi_idx;
    limb_t              a_w;
    limb_t              b_w;
    limb_t              r_w;
    logic               cin_w;
    logic               cout_w;
    logic               last_w;
    logic               step_w;
    logic               op_sign_w;
    logic               ovf_hit;

    // Select the limb being worked on this cycle and its operand word.
    always_comb begin
        pos       = busy_q ? cnt_q : '0;
        hi_idx    = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        a_w       = sum_q[pos*LIMB_W +: LIMB_W];
        b_w       = busy_q ? op_hi_q[hi_idx*LIMB_W +: LIMB_W] : op_data_i[LIMB_W-1:0];
        cin_w     = busy_q & carry_q;
        last_w    = (pos == LAST_POS);
        step_w    = busy_q | op_valid_i;
        op_sign_w = busy_q ? op_hi_q[HI_W-1] : op_data_i[TOTAL_W-1];
    end

    wfx_limb_add u_add (
        .a_i   (a_w),
        .b_i   (b_w),
        .cin_i (cin_w),
        .sum_o (r_w),
        .cout_o(cout_w)
    );

    wfx_sign_ovf u_ovf (
        .acc_sign_i(sum_q[TOTAL_W-1]),
        .op_sign_i (op_sign_w),
        .res_sign_i(r_w[LIMB_W-1]),
        .ovf_o     (ovf_hit)
    );

    // Limb sequencer: accept, step limbs upward, finish on word 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_q   <= '0;
            op_hi_q <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (clr_i) begin
            sum_q   <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            carry_q <= 1'b0;
            ovf_q   <= 1'b0;
        end else if (step_w) begin
            sum_q[pos*LIMB_W +: LIMB_W] <= r_w;
            carry_q                     <= cout_w;
            if (!busy_q) begin
                op_hi_q <= op_data_i[TOTAL_W-1 -: HI_W];
            end
            if (last_w) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
                if (ovf_hit) begin
                    ovf_q <= 1'b1;
                end
            end else begin
                busy_q <= 1'b1;
                cnt_q  <= pos + 1'b1;
            end
        end
    end

    assign op_ready_o = ~busy_q;
    assign sum_o      = sum_q;
    assign ovf_o      = ovf_q;
endmodule

// File: rtl/wfx_accum.sv
// Order-invariant wide fixed-point accumulator. SERIAL picks the datapath:
// 1 = one limb per cycle with a carry register, 0 = full width in one cycle.
// Assumes operands are two's complement with word 0 most significant.
module wfx_accum
    import wfx_acc_pkg::*;
#(
    parameter int unsigned NUM_LIMBS = 3,
    parameter bit          SERIAL    = 1'b1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr_i,
    input  logic                        op_valid_i,
    input  logic [NUM_LIMBS*LIMB_W-1:0] op_data_i,
    output logic                        op_ready_o,
    output logic [NUM_LIMBS*LIMB_W-1:0] sum_o,
    output logic                        ovf_o
);
    if (SERIAL) begin : g_ser
        wfx_core_ser #(.NUM_LIMBS(NUM_LIMBS)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr_i),
            .op_valid_i(op_valid_i),
            .op_data_i (op_data_i),
            .op_ready_o(op_ready_o),
            .sum_o     (sum_o),
            .ovf_o     (ovf_o)
        );
    end else begin : g_par
        wfx_core_par #(.NUM_LIMBS(NUM_LIMBS)) u_core (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr_i     (clr_i),
            .op_valid_i(op_valid_i),
            .op_data_i (op_data_i),
            .op_ready_o(op_ready_o),
            .sum_o     (sum_o),
            .ovf_o     (ovf_o)
        );
    end
endmodule

// File: rtl/wfx_accum_chk.sv
// Port-level protocol checker for wfx_accum, attached by bind below.
// Counts consecutive not-ready cycles to bound the serial busy window.
module wfx_accum_chk
    import wfx_acc_pkg::*;
#(
    parameter int unsigned NUM_LIMBS = 3,
    parameter bit          SERIAL    = 1'b1
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        clr_i,
    input logic                        op_valid_i,
    input logic [NUM_LIMBS*LIMB_W-1:0] op_data_i,
    input logic                        op_ready_o,
    input logic [NUM_LIMBS*LIMB_W-1:0] sum_o,
    input logic                        ovf_o
);
    localparam int unsigned LW = $clog2(NUM_LIMBS + 1) + 1;
    localparam logic [LW-1:0] MAX_LOW = LW'(NUM_LIMBS - 1);

    logic [LW-1:0] low_cnt;
    logic          data_seen_unused;

    assign data_seen_unused = ^op_data_i;

    // Consecutive cycles with ready low before the current one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (op_ready_o) begin
            low_cnt <= '0;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (sum_o == '0) && !ovf_o && op_ready_o); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_o && !clr_i) |=> ovf_o); // R4
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (op_ready_o && !op_valid_i && !clr_i) |=> $stable(sum_o)); // R10
    AST_NO_SPURIOUS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_o && op_ready_o && !op_valid_i && !clr_i) |=> !ovf_o); // R3

    if (SERIAL) begin : g_ser_chk
        if (NUM_LIMBS > 1) begin : g_multi
            AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
                (op_valid_i && op_ready_o && !clr_i) |=> !op_ready_o); // R7
        end
        AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            !op_ready_o |-> (low_cnt < MAX_LOW)); // R7
    end else begin : g_par_chk
        AST_READY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            op_ready_o); // R6
    end
endmodule

bind wfx_accum wfx_accum_chk #(.NUM_LIMBS(NUM_LIMBS), .SERIAL(SERIAL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr_i),
    .op_valid_i(op_valid_i),
    .op_data_i (op_data_i),
    .op_ready_o(op_ready_o),
    .sum_o     (sum_o),
    .ovf_o     (ovf_o)
);

// File: tb/tb_wfx_accum.sv
// Bench: drives a limb-serial instance (dut) and a single-cycle instance
// (dut_par) and compares each one against a behavioural model every cycle.
module tb_wfx_accum;
    localparam int CLK_PERIOD = 10;
    localparam int NL         = 3;
    localparam int TW         = NL * 64;
    localparam int PAIRS      = 8;
    localparam int WATCHDOG   = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          v_s = 1'b0;
    logic          v_p = 1'b0;
    logic [TW-1:0] d = '0;
    logic          rdy_s, rdy_p, ovf_s, ovf_p;
    logic [TW-1:0] sum_s, sum_p;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;
    string cur_req = "R1";

    // Model state
    logic [TW-1:0] ms_sum, mp_sum, ps_sum;
    logic          ms_ovf, mp_ovf, ps_ovf;
    int            ms_left;

    localparam logic [TW-1:0] MAXPOS = {1'b0, {(TW-1){1'b1}}};
    localparam logic [TW-1:0] MINNEG = {1'b1, {(TW-1){1'b0}}};

    wfx_accum #(.NUM_LIMBS(NL), .SERIAL(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .op_valid_i(v_s), .op_data_i(d),
        .op_ready_o(rdy_s), .sum_o(sum_s), .ovf_o(ovf_s));

    wfx_accum #(.NUM_LIMBS(NL), .SERIAL(1'b0)) dut_par (
        .clk(clk), .rst_n(rst_n), .clr_i(clr), .op_valid_i(v_p), .op_data_i(d),
        .op_ready_o(rdy_p), .sum_o(sum_p), .ovf_o(ovf_p));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit sgn_ovf(input logic [TW-1:0] a, b, r);
        return (a[TW-1] == b[TW-1]) && (r[TW-1] != a[TW-1]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [TW-1:0] act, exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Behavioural model: exact wide sums with the stated latencies.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n || clr) begin
            ms_sum <= '0; ms_ovf <= 1'b0; ms_left <= 0;
            mp_sum <= '0; mp_ovf <= 1'b0;
        end else begin
            if (ms_left == 0) begin
                if (v_s) begin
                    ps_sum = ms_sum + d;
                    ps_ovf = sgn_ovf(ms_sum, d, ps_sum);
                    if (NL == 1) begin
                        ms_sum <= ps_sum;
                        if (ps_ovf) ms_ovf <= 1'b1;
                    end else begin
                        ms_left <= NL - 1;
                    end
                end
            end else begin
                if (ms_left == 1) begin
                    ms_sum <= ps_sum;
                    if (ps_ovf) ms_ovf <= 1'b1;
                end
                ms_left <= ms_left - 1;
            end
            if (v_p) begin
                mp_sum <= mp_sum + d;
                if (sgn_ovf(mp_sum, d, mp_sum + d)) mp_ovf <= 1'b1;
            end
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rdy_s == (ms_left == 0), "R7", TW'(rdy_s), TW'(ms_left == 0));
            if (ms_left == 0) chk(sum_s == ms_sum, cur_req, sum_s, ms_sum);
            chk(ovf_s == ms_ovf, "R3", TW'(ovf_s), TW'(ms_ovf));
            chk(rdy_p == 1'b1, "R6", TW'(rdy_p), TW'(1));
            chk(sum_p == mp_sum, cur_req, sum_p, mp_sum);
            chk(ovf_p == mp_ovf, "R3", TW'(ovf_p), TW'(mp_ovf));
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        if (cyc > WATCHDOG && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, WATCHDOG);
            finish_run();
        end
    end

    // All stimulus tasks start and end one time unit after a rising edge.
    task automatic step();
        @(posedge clk); #1;
    endtask
    task automatic send_s(input logic [TW-1:0] val);
        while (!rdy_s) step();
        v_s = 1'b1; d = val; step(); v_s = 1'b0;
    endtask
    task automatic idle_s();
        while (!rdy_s) step();
    endtask
    task automatic send_p(input logic [TW-1:0] val);
        v_p = 1'b1; d = val; step(); v_p = 1'b0;
    endtask
    task automatic send_both(input logic [TW-1:0] val);
        send_s(val); idle_s(); send_p(val);
    endtask
    task automatic do_clr();
        clr = 1'b1; step(); clr = 1'b0;
    endtask

    logic [TW-1:0] pool [2*PAIRS];

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R9: reset state
        chk(sum_s == '0 && !ovf_s && rdy_s, "R9", sum_s, '0);
        chk(sum_p == '0 && !ovf_p && rdy_p, "R9", sum_p, '0);
        rst_n = 1'b1;

        // R2: carry through both lower limbs
        cur_req = "R2";
        do_clr();
        send_both({64'd0, {128{1'b1}}});
        send_both(TW'(1));
        idle_s();
        chk(sum_s == (TW'(1) << 128), "R2", sum_s, TW'(1) << 128);
        chk(sum_p == (TW'(1) << 128), "R2", sum_p, TW'(1) << 128);

        // R7 / R10: busy window and operands offered while busy
        cur_req = "R7";
        do_clr();
        send_s(TW'(5));
        chk(!rdy_s, "R7", TW'(rdy_s), '0);
        v_s = 1'b1; d = TW'(77);
        step();
        chk(!rdy_s, "R7", TW'(rdy_s), '0);
        step();
        v_s = 1'b0;
        chk(rdy_s, "R7", TW'(rdy_s), TW'(1));
        chk(sum_s == TW'(5), "R10", sum_s, TW'(5));

        // R6: back-to-back single-cycle operands
        cur_req = "R6";
        v_p = 1'b1; d = TW'(3); step();
        chk(sum_p == TW'(3), "R6", sum_p, TW'(3));
        d = TW'(4); step(); v_p = 1'b0;
        chk(sum_p == TW'(7), "R6", sum_p, TW'(7));

        // R3 / R4: positive overflow, then stickiness
        cur_req = "R3";
        do_clr();
        send_both(MAXPOS);
        send_both(TW'(1));
        chk(sum_s == MINNEG && ovf_s, "R3", sum_s, MINNEG);
        chk(sum_p == MINNEG && ovf_p, "R3", sum_p, MINNEG);
        send_both(TW'(3));
        chk(ovf_s && sum_s == MINNEG + TW'(3), "R4", TW'(ovf_s), TW'(1));
        chk(ovf_p, "R4", TW'(ovf_p), TW'(1));

        // R3: negative overflow
        do_clr();
        send_both(MINNEG);
        send_both({TW{1'b1}});
        chk(sum_s == MAXPOS && ovf_s, "R3", sum_s, MAXPOS);
        chk(sum_p == MAXPOS && ovf_p, "R3", sum_p, MAXPOS);

        // R3: mixed signs never overflow
        do_clr();
        send_both(MAXPOS);
        send_both(MINNEG);
        chk(sum_s == {TW{1'b1}} && !ovf_s, "R3", sum_s, {TW{1'b1}});
        chk(sum_p == {TW{1'b1}} && !ovf_p, "R3", sum_p, {TW{1'b1}});

        // R5: clear aborts a serial addition and drops a concurrent operand
        cur_req = "R5";
        send_s(TW'(9));
        v_p = 1'b1; d = TW'(11); clr = 1'b1;
        step();
        clr = 1'b0; v_p = 1'b0;
        chk(sum_s == '0 && !ovf_s && rdy_s, "R5", sum_s, '0);
        chk(sum_p == '0 && !ovf_p, "R5", sum_p, '0);

        // R8: values and their negatives in several orders sum to zero
        cur_req = "R8";
        for (int i = 0; i < PAIRS; i++) begin
            logic [TW-1:0] r;
            r = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
            pool[i]         = {{(TW-180){r[179]}}, r[179:0]};
            pool[i + PAIRS] = -pool[i];
        end
        for (int t = 0; t < 3; t++) begin
            do_clr();
            for (int i = 2*PAIRS - 1; i > 0; i--) begin
                int j;
                logic [TW-1:0] tmp;
                j = $urandom_range(i, 0);
                tmp = pool[i]; pool[i] = pool[j]; pool[j] = tmp;
            end
            for (int i = 0; i < 2*PAIRS; i++) send_both(pool[i]);
            idle_s();
            chk(sum_s == '0 && !ovf_s, "R8", sum_s, '0);
            chk(sum_p == '0 && !ovf_p, "R8", sum_p, '0);
        end

        // R1: plain modular sum across mixed operands
        cur_req = "R1";
        do_clr();
        send_both({64'h1, 64'h2, 64'h3});
        send_both({64'h10, 64'hffff_ffff_ffff_ffff, 64'hffff_ffff_ffff_fffe});
        chk(sum_s == {64'h12, 64'h2, 64'h1}, "R1", sum_s, {64'h12, 64'h2, 64'h1});
        chk(sum_p == {64'h12, 64'h2, 64'h1}, "R1", sum_p, {64'h12, 64'h2, 64'h1});

        step();
        finish_run();
    end
endmodule